// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and Completion Unit

This block keeps the interrupt state of a single processor in a multi-source interrupt controller. It receives, for every source, the pending bit for this processor, a 4-bit priority, a vector, a level/edge flag and a multicast flag. It holds the processor's task priority, the spurious vector, the processor's in-service bitmap and a nested notion of the interrupt currently being serviced. It drives the processor's interrupt request line.

The processor reads an acknowledge strobe to take the best deliverable interrupt and writes a completion strobe when its handler finishes. Completion pops back to the highest-priority interrupt still in service, so handlers can nest. The source side raises the request line through a raise strobe that also names a candidate source. On every delivery of an edge source, the unit emits a one-cycle clear request so the source side can drop its pending state. Trigger qualification and target selection stay outside the block.

Top module: `cpu_irq_port`

## Requirements
- R1: The task priority `tpr_o` is 15 after reset, and a write with `tpr_wr_i` loads `tpr_wdata_i` (4 bits, i.e. the value modulo 16) on the next edge.
- R2: The spurious vector `spur_o` is 0xFF after reset, and a write with `spur_wr_i` loads the 8-bit `spur_wdata_i`.
- R3: A source qualifies for delivery only when its priority is strictly above the task priority and, if an interrupt is in service, strictly above the priority of the current in-service source.
- R4: On an acknowledge, the candidate named by the last raise is delivered if its pending bit is still set and it qualifies. Otherwise the pending source with the highest priority is chosen, with the lower index winning a tie, and it is delivered only if it qualifies.
- R5: When nothing qualifies, an acknowledge returns the spurious vector, leaves the in-service bitmap unchanged and drops the candidate.
- R6: A delivery sets the source's bit in `insvc_o`, makes it the current in-service source and deasserts `irq_o`. One cycle after the acknowledge edge, `ack_valid_o` is 1 and `ack_data_o` carries the source's vector.
- R7: Alongside a delivery, `clr_valid_o` pulses for edge sources only (`src_level_i`=0). `clr_idx_o` names the source. `clr_all_o` is 1 for a normal source (clear the whole pending mask) and 0 for a multicast source (clear only this processor's bit). A level source produces no pulse.
- R8: A completion write while nothing is in service changes neither `insvc_o` nor `irq_o`.
- R9: A completion clears the current source's in-service bit, and the highest-priority remaining in-service source (lower index on a tie) becomes current for the R3 rule.
- R10: After a completion, if the highest-priority pending source qualifies against the resumed state, it becomes the candidate and `irq_o` is asserted. Otherwise the candidate is dropped and `irq_o` keeps its value.
- R11: A raise strobe records `raise_idx_i` as the candidate and asserts `irq_o`. An acknowledge takes precedence over a completion, and a completion takes precedence over a raise, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend_i | input | NSRC | Pending bit of each source for this processor |
| src_level_i | input | NSRC | 1 = level-sensitive source, 0 = edge source |
| src_mcast_i | input | NSRC | 1 = multicast source |
| src_prio_i | input | NSRC*4 | Packed 4-bit priorities, source i at bits [4i+3:4i] |
| src_vec_i | input | NSRC*VEC_W | Packed vectors, source i at bits [VEC_W*i +: VEC_W] |
| raise_i | input | 1 | Source side raises the request for a candidate |
| raise_idx_i | input | IDX_W | Candidate source index for a raise |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| eoi_wr_i | input | 1 | Completion write strobe |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 4 | Task priority write data |
| spur_wr_i | input | 1 | Spurious vector write strobe |
| spur_wdata_i | input | VEC_W | Spurious vector write data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge read data valid |
| ack_data_o | output | VEC_W | Acknowledged vector or the spurious vector |
| insvc_o | output | NSRC | In-service bitmap for this processor |
| clr_valid_o | output | 1 | Pending-clear request for a delivered edge source |
| clr_idx_o | output | IDX_W | Source to clear |
| clr_all_o | output | 1 | 1 = clear the whole pending mask, 0 = this processor's bit only |
| tpr_o | output | 4 | Current task priority |
| spur_o | output | VEC_W | Current spurious vector |

## Verification
The hardest situation to reach is a nest of two or more in-service interrupts that unwinds through completions while pending sources of equal and lower priority wait. Only that nest shows whether the resumed priority, and not the task priority alone, gates the re-raise and later acknowledges. The directed part builds a two-deep nest and then acknowledges an equal-priority pending source while the outer handler is resumed. It also keeps a stale, lower-priority candidate in play so that the candidate-first order is visible. Random sequences then mix raises, acknowledges, completions and priority rewrites with mostly low task priorities, so that deep nests form often. All of these are compared against a bench model of the same rules.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int PRIO_W = 4;

  // Strict qualification against task priority and the active in-service priority
  function automatic logic beats(input logic [PRIO_W-1:0] p,
                                 input logic [PRIO_W-1:0] tpr,
                                 input logic              is_v,
                                 input logic [PRIO_W-1:0] is_p);
    return (p > tpr) && (!is_v || (p > is_p));
  endfunction
endpackage

// File: rtl/cpu_irq_pick.sv
module cpu_irq_pick
  import cpu_irq_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        mask_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  always_comb begin
    logic              f;
    logic [IDX_W-1:0]  bi;
    logic [PRIO_W-1:0] bp;
    f  = 1'b0;
    bi = '0;
    bp = '0;
    // strict compare keeps the lower index on equal priority
    for (int i = 0; i < NSRC; i++) begin
      if (mask_i[i] && (!f || (prio_i[i*PRIO_W +: PRIO_W] > bp))) begin
        f  = 1'b1;
        bi = IDX_W'(i);
        bp = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    found_o = f;
    idx_o   = bi;
  end
endmodule

// File: rtl/cpu_irq_cfg.sv
module cpu_irq_cfg
  import cpu_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tpr_wr_i,
  input  logic [PRIO_W-1:0] tpr_wdata_i,
  input  logic              spur_wr_i,
  input  logic [VEC_W-1:0]  spur_wdata_i,
  output logic [PRIO_W-1:0] tpr_o,
  output logic [VEC_W-1:0]  spur_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_o  <= '1;
      spur_o <= '1;
    end else begin
      if (tpr_wr_i)  tpr_o  <= tpr_wdata_i;
      if (spur_wr_i) spur_o <= spur_wdata_i;
    end
  end
endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
  import cpu_irq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_pend_i,
  input  logic [NSRC-1:0]        src_level_i,
  input  logic [NSRC-1:0]        src_mcast_i,
  input  logic [NSRC*PRIO_W-1:0] src_prio_i,
  input  logic [NSRC*VEC_W-1:0]  src_vec_i,
  input  logic                   raise_i,
  input  logic [IDX_W-1:0]       raise_idx_i,
  input  logic                   ack_rd_i,
  input  logic                   eoi_wr_i,
  input  logic                   tpr_wr_i,
  input  logic [PRIO_W-1:0]      tpr_wdata_i,
  input  logic                   spur_wr_i,
  input  logic [VEC_W-1:0]       spur_wdata_i,
  output logic                   irq_o,
  output logic                   ack_valid_o,
  output logic [VEC_W-1:0]       ack_data_o,
  output logic [NSRC-1:0]        insvc_o,
  output logic                   clr_valid_o,
  output logic [IDX_W-1:0]       clr_idx_o,
  output logic                   clr_all_o,
  output logic [PRIO_W-1:0]      tpr_o,
  output logic [VEC_W-1:0]       spur_o
);
  function automatic logic [PRIO_W-1:0] prio_at(input logic [IDX_W-1:0] idx);
    return src_prio_i[idx*PRIO_W +: PRIO_W];
  endfunction

  function automatic logic [NSRC-1:0] bit_of(input logic [IDX_W-1:0] idx);
    return NSRC'(1) << idx;
  endfunction

  logic             cur_v_q,  cand_v_q;
  logic [IDX_W-1:0] cur_idx_q, cand_idx_q;

  cpu_irq_cfg #(.VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .tpr_wr_i(tpr_wr_i), .tpr_wdata_i(tpr_wdata_i),
    .spur_wr_i(spur_wr_i), .spur_wdata_i(spur_wdata_i),
    .tpr_o(tpr_o), .spur_o(spur_o)
  );

  // best pending source for this processor
  logic             pend_found;
  logic [IDX_W-1:0] pend_idx;
  cpu_irq_pick #(.NSRC(NSRC)) u_pick_pend (
    .mask_i(src_pend_i), .prio_i(src_prio_i),
    .found_o(pend_found), .idx_o(pend_idx)
  );

  // best in-service source left once the current one completes
  logic [NSRC-1:0]  insvc_rem;
  logic             rem_found;
  logic [IDX_W-1:0] rem_idx;
  assign insvc_rem = insvc_o & ~bit_of(cur_idx_q);
  cpu_irq_pick #(.NSRC(NSRC)) u_pick_rem (
    .mask_i(insvc_rem), .prio_i(src_prio_i),
    .found_o(rem_found), .idx_o(rem_idx)
  );

  // named events, also watched by the checker
  logic             cand_ok, best_ok, deliver_w, eoi_w, resume_ok;
  logic [IDX_W-1:0] win_idx;
  assign cand_ok   = cand_v_q && src_pend_i[cand_idx_q]
                     && beats(prio_at(cand_idx_q), tpr_o, cur_v_q, prio_at(cur_idx_q));
  assign best_ok   = pend_found
                     && beats(prio_at(pend_idx), tpr_o, cur_v_q, prio_at(cur_idx_q));
  assign win_idx   = cand_ok ? cand_idx_q : pend_idx;
  assign deliver_w = ack_rd_i && (cand_ok || best_ok);
  assign eoi_w     = eoi_wr_i && !ack_rd_i && cur_v_q;
  assign resume_ok = pend_found
                     && beats(prio_at(pend_idx), tpr_o, rem_found, prio_at(rem_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_o     <= '0;
      cur_v_q     <= 1'b0;
      cur_idx_q   <= '0;
      cand_v_q    <= 1'b0;
      cand_idx_q  <= '0;
      irq_o       <= 1'b0;
      ack_valid_o <= 1'b0;
      ack_data_o  <= '0;
      clr_valid_o <= 1'b0;
      clr_idx_o   <= '0;
      clr_all_o   <= 1'b0;
    end else begin
      ack_valid_o <= ack_rd_i;
      clr_valid_o <= 1'b0;
      if (ack_rd_i) begin
        cand_v_q <= 1'b0;
        if (deliver_w) begin
          insvc_o     <= insvc_o | bit_of(win_idx);
          cur_v_q     <= 1'b1;
          cur_idx_q   <= win_idx;
          irq_o       <= 1'b0;
          ack_data_o  <= src_vec_i[win_idx*VEC_W +: VEC_W];
          clr_valid_o <= !src_level_i[win_idx];
          clr_idx_o   <= win_idx;
          clr_all_o   <= !src_mcast_i[win_idx];
        end else begin
          ack_data_o  <= spur_o;
        end
      end else if (eoi_w) begin
        insvc_o   <= insvc_rem;
        cur_v_q   <= rem_found;
        cur_idx_q <= rem_idx;
        cand_v_q  <= resume_ok;
        if (resume_ok) begin
          cand_idx_q <= pend_idx;
          irq_o      <= 1'b1;
        end
      end else if (raise_i) begin
        cand_v_q   <= 1'b1;
        cand_idx_q <= raise_idx_i;
        irq_o      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpu_irq_port_chk.sv
module cpu_irq_port_chk #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_rd_i,
  input logic             eoi_wr_i,
  input logic             deliver_w,
  input logic             eoi_w,
  input logic             irq_o,
  input logic             ack_valid_o,
  input logic [VEC_W-1:0] ack_data_o,
  input logic [VEC_W-1:0] spur_o,
  input logic [NSRC-1:0]  insvc_o,
  input logic             clr_valid_o
);
  // R6
  deliver_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_w |=> !irq_o);

  // R6
  deliver_adds_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_w |=> ($countones(insvc_o) == $countones($past(insvc_o)) + 1));

  // R5
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && !deliver_w) |=> (ack_data_o == $past(spur_o)) && $stable(insvc_o));

  // R8
  idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr_i && !ack_rd_i && (insvc_o == '0)) |=> $stable(insvc_o) && $stable(irq_o));

  // R9
  eoi_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_w |=> ($countones(insvc_o) + 1 == $countones($past(insvc_o))));

  // R7
  clr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_o |-> ack_valid_o);
endmodule

bind cpu_irq_port cpu_irq_port_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_rd_i(ack_rd_i), .eoi_wr_i(eoi_wr_i),
  .deliver_w(deliver_w), .eoi_w(eoi_w), .irq_o(irq_o),
  .ack_valid_o(ack_valid_o), .ack_data_o(ack_data_o), .spur_o(spur_o),
  .insvc_o(insvc_o), .clr_valid_o(clr_valid_o)
);

// File: tb/cpu_irq_port_tb.sv
`timescale 1ns/1ps
module cpu_irq_port_tb;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] pend = '0, lvl = '0, mc = '0;
  logic [3:0]   prio [N];
  logic [7:0]   vec  [N];
  logic [N*4-1:0] prio_f;
  logic [N*8-1:0] vec_f;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      prio_f[i*4 +: 4] = prio[i];
      vec_f[i*8 +: 8]  = vec[i];
    end
  end

  logic raise = 0, ack_rd = 0, eoi_wr = 0, tpr_wr = 0, spur_wr = 0;
  logic [2:0] raise_idx = '0;
  logic [3:0] tpr_wd = '0;
  logic [7:0] spur_wd = '0;
  logic irq_o, ack_valid_o, clr_valid_o, clr_all_o;
  logic [7:0] ack_data_o, spur_o;
  logic [N-1:0] insvc_o;
  logic [2:0] clr_idx_o;
  logic [3:0] tpr_o;

  cpu_irq_port #(.NSRC(N), .VEC_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_pend_i(pend), .src_level_i(lvl),
    .src_mcast_i(mc), .src_prio_i(prio_f), .src_vec_i(vec_f),
    .raise_i(raise), .raise_idx_i(raise_idx), .ack_rd_i(ack_rd),
    .eoi_wr_i(eoi_wr), .tpr_wr_i(tpr_wr), .tpr_wdata_i(tpr_wd),
    .spur_wr_i(spur_wr), .spur_wdata_i(spur_wd), .irq_o(irq_o),
    .ack_valid_o(ack_valid_o), .ack_data_o(ack_data_o), .insvc_o(insvc_o),
    .clr_valid_o(clr_valid_o), .clr_idx_o(clr_idx_o), .clr_all_o(clr_all_o),
    .tpr_o(tpr_o), .spur_o(spur_o)
  );

  int total = 0, bad = 0;
  // bench model
  logic [3:0] m_tpr = 4'hF;
  logic [7:0] m_spur = 8'hFF;
  logic [N-1:0] m_insvc = '0;
  logic m_cur_v = 0, m_cand_v = 0, m_irq = 0;
  int m_cur = 0, m_cand = 0;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit qual(int p, bit is_v, int is_p);
    return (p > m_tpr) && (!is_v || p > is_p);
  endfunction

  function automatic int best_of(logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || prio[i] > prio[b])) b = i;
    return b;
  endfunction

  task automatic common(string req);
    check(req, "irq", irq_o, m_irq);
    check(req, "insvc", insvc_o, m_insvc);
    check(req, "tpr", tpr_o, m_tpr);
    check(req, "spur", spur_o, m_spur);
  endtask

  task automatic do_ack(string req, int lit = -1);
    int w = -1, b;
    int ed;
    bit ec = 0, ea = 0;
    if (m_cand_v && pend[m_cand] && qual(prio[m_cand], m_cur_v, prio[m_cur])) w = m_cand;
    else begin
      b = best_of(pend);
      if (b >= 0 && qual(prio[b], m_cur_v, prio[m_cur])) w = b;
    end
    m_cand_v = 0;
    if (w >= 0) begin
      ed = vec[w]; m_insvc[w] = 1; m_cur_v = 1; m_cur = w; m_irq = 0;
      ec = !lvl[w]; ea = !mc[w];
    end else ed = m_spur;
    @(negedge clk) ack_rd = 1;
    @(negedge clk) ack_rd = 0;
    check(req, "ack_valid", ack_valid_o, 1);
    check(req, "ack_data", ack_data_o, ed);
    if (lit >= 0) check(req, "ack_data_lit", ack_data_o, lit);
    check(req, "clr_valid", clr_valid_o, ec);
    if (ec) begin
      check(req, "clr_idx", clr_idx_o, w);
      check(req, "clr_all", clr_all_o, ea);
      pend[w] = 0;
    end
    common(req);
  endtask

  task automatic do_eoi(string req);
    int r, b;
    if (m_cur_v) begin
      m_insvc[m_cur] = 0;
      r = best_of(m_insvc);
      m_cur_v = (r >= 0); m_cur = (r >= 0) ? r : 0;
      b = best_of(pend);
      if (b >= 0 && qual(prio[b], r >= 0, (r >= 0) ? prio[r] : 0)) begin
        m_cand = b; m_cand_v = 1; m_irq = 1;
      end else m_cand_v = 0;
    end
    @(negedge clk) eoi_wr = 1;
    @(negedge clk) eoi_wr = 0;
    common(req);
  endtask

  task automatic do_raise(string req, int idx);
    m_cand = idx; m_cand_v = 1; m_irq = 1;
    @(negedge clk) begin raise = 1; raise_idx = 3'(idx); end
    @(negedge clk) raise = 0;
    common(req);
  endtask

  task automatic do_tpr(string req, int v);
    m_tpr = 4'(v);
    @(negedge clk) begin tpr_wr = 1; tpr_wd = 4'(v); end
    @(negedge clk) tpr_wr = 0;
    common(req);
  endtask

  task automatic do_spur(string req, int v);
    m_spur = 8'(v);
    @(negedge clk) begin spur_wr = 1; spur_wd = 8'(v); end
    @(negedge clk) spur_wr = 0;
    common(req);
  endtask

  task automatic set_src(int i, int p, bit pd, bit l, bit m);
    @(negedge clk) begin prio[i] = 4'(p); pend[i] = pd; lvl[i] = l; mc[i] = m; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin prio[i] = 4'(i); vec[i] = 8'(8'h40 + i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 reset state
    check("R1", "tpr_reset", tpr_o, 15);
    check("R2", "spur_reset", spur_o, 8'hFF);
    common("R1");
    // R3: task priority 15 blocks everything
    set_src(5, 9, 1, 0, 0);
    do_ack("R3", 8'hFF);
    do_tpr("R1", 3);
    set_src(2, 5, 1, 0, 0);
    set_src(6, 9, 1, 0, 0);
    // R4 tie goes to lower index, R7 normal edge clears whole mask
    do_ack("R4", 8'h45);
    check("R7", "clr_all_normal", clr_all_o, 1);
    // R3 equal to in-service priority does not qualify
    do_ack("R3", 8'hFF);
    // R11 raise, R7 multicast clears own bit only
    set_src(7, 12, 1, 0, 1);
    do_raise("R11", 7);
    check("R11", "irq_raised", irq_o, 1);
    do_ack("R7", 8'h47);
    check("R7", "clr_all_mcast", clr_all_o, 0);
    // R9 R10 pop to source 5, nothing beats 9
    do_eoi("R10");
    check("R9", "insvc_after_pop", insvc_o, 8'h20);
    check("R10", "irq_kept_low", irq_o, 0);
    do_ack("R9", 8'hFF);
    // R10 last completion, source 6 now qualifies
    do_eoi("R10");
    check("R10", "irq_reraised", irq_o, 1);
    do_ack("R10", 8'h46);
    do_eoi("R9");
    // R8 completion with nothing in service
    check("R8", "insvc_empty", insvc_o, 0);
    do_eoi("R8");
    check("R8", "insvc_still_empty", insvc_o, 0);
    // R4 stale candidate beats higher pending; R7 level keeps pending
    set_src(2, 5, 1, 1, 0);
    set_src(3, 8, 1, 0, 0);
    do_raise("R4", 2);
    do_ack("R4", 8'h42);
    check("R7", "level_no_clr", clr_valid_o, 0);
    do_eoi("R4");
    // R4 candidate no longer pending -> search
    do_raise("R4", 1);
    do_ack("R4", 8'h43);
    do_eoi("R4");
    // R2 written spurious vector returned
    do_spur("R2", 8'h33);
    pend = '0;
    do_ack("R5", 8'h33);
    // constrained random
    for (int k = 0; k < 600; k++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: do_ack("R4");
        3, 4:    do_eoi("R9");
        5:       do_raise("R11", $urandom_range(0, N-1));
        6:       do_tpr("R1", ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 4));
        7:       do_spur("R2", $urandom_range(0, 255));
        default: begin
          int s = $urandom_range(0, N-1);
          set_src(s, $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
          @(negedge clk);
          common("R3");
        end
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule